// File: doc/BRIEF.md
# DDR Clock Retune and DLL Relock Sequencer

This block steps a DDR memory subsystem through a change of its memory clock frequency. It resets the PHY delay-locked loop, asks the clock generator for the new frequency, and then waits a fixed number of memory clock cycles for the loop to settle. It never reads a lock flag. Software or a boot controller pulses `start_i` together with two options. `keep_i` asks that memory contents survive the change. `freq_change_i` says whether the frequency really moves. The block then runs on its own until it pulses `done_o`.

When contents must survive, the sequence is wrapped inside a self-refresh period. The block first waits for the memory controller to report idle, then requests self-refresh and waits for the acknowledge. After the clock work it drops the request and waits for the acknowledge to clear before it reports completion. In DDR3 mode, leaving self-refresh also produces a one-cycle request for a long ZQ calibration. If the frequency does not change, the DLL reset, the clock handshake and the settle wait are all left out. If contents need not survive, self-refresh is never touched.

Every handshake is a level handshake, synchronous to `clk`.

Top module: `dclk_relock_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, every output is low.
- R2: `clkgen_req_o` rises in the same cycle as `dll_rst_o`. It stays high until `clkgen_ack_i` is seen high, then falls. The sequence does not go on until `clkgen_ack_i` is low again.
- R3: `dll_rst_o` stays high from the clock request until `clkgen_ack_i` has been seen high and then low. It is released in the cycle after the acknowledge is seen low.
- R4: After `dll_rst_o` falls, the block waits exactly LOCK_CYCLES clock cycles (default 9000) with no status input. On the cold path, `done_o` is high on the LOCK_CYCLES-th cycle after the first cycle with `dll_rst_o` low.
- R5: On the preserving path, `sr_req_o` rises only after `ctrl_idle_i` has been seen high. `dll_rst_o` rises only after `sr_ack_i` has been seen high. `sr_req_o` then stays high through the whole clock change and the settle wait.
- R6: On the preserving path, `sr_req_o` falls after the settle wait. `done_o` comes only after `sr_ack_i` has been seen low.
- R7: With `freq_change_i` low at start, neither `dll_rst_o` nor `clkgen_req_o` is raised.
- R8: With `keep_i` low at start, `sr_req_o` is never raised, whether or not the frequency changes.
- R9: `zq_long_o` is high for exactly the `done_o` cycle of a run that used self-refresh with `ddr3_i` high at start. In every other run it stays low.
- R10: `start_i` is ignored while `busy_o` is high. `keep_i`, `freq_change_i` and `ddr3_i` are taken only in the cycle that a start is accepted.
- R11: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; every handshake is synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (accepted only when idle) |
| keep_i | input | 1 | Preserve memory contents through self-refresh |
| freq_change_i | input | 1 | The clock frequency is to be changed |
| ddr3_i | input | 1 | Memory is DDR3, so issue a long ZQ calibration on self-refresh exit |
| ctrl_idle_i | input | 1 | Memory controller has no traffic in flight |
| sr_ack_i | input | 1 | Memory controller is in self-refresh |
| clkgen_ack_i | input | 1 | Clock generator has applied the new frequency |
| dll_rst_o | output | 1 | Holds the PHY DLL in reset |
| sr_req_o | output | 1 | Self-refresh request to the memory controller |
| clkgen_req_o | output | 1 | Frequency change request to the clock generator |
| zq_long_o | output | 1 | One-cycle long ZQ calibration request |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second start arriving in the middle of a 9000-cycle settle wait, with option inputs that would pick a different path. The stimulus pulses start again, with preserve set and frequency change clear, while a cold run is still waiting. It then checks that self-refresh never rises and that the settle length stays exactly LOCK_CYCLES. Acknowledge responders with a fixed lag, and a controller idle signal that is held back for several cycles, force the preserving path to sit in each of its wait states. A behavioural model follows every cycle of each run.

// File: rtl/relock_pkg.sv
package relock_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_IDLE,
    ST_SR_ENTER,
    ST_CLK_REQ,
    ST_CLK_DROP,
    ST_LOCK,
    ST_SR_EXIT,
    ST_FINISH
  } relock_state_e;

  // Value loaded into the settle counter so that it reaches zero
  // after exactly 'cycles' cycles of counting.
  function automatic int unsigned lock_reload(int unsigned cycles);
    return (cycles == 0) ? 0 : cycles - 1;
  endfunction

endpackage

// File: rtl/relock_wait_timer.sv
module relock_wait_timer #(
  parameter int unsigned CYCLES = 9000,
  parameter int unsigned CW     = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  localparam logic [CW-1:0] RELOAD = CW'(relock_pkg::lock_reload(CYCLES));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load_i)                  cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4: a load followed by a count never leaves the counter above the reload value
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i) |=> (cnt_q <= RELOAD));

endmodule

// File: rtl/relock_opt_reg.sv
module relock_opt_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_i,
  input  logic keep_i,
  input  logic freq_i,
  input  logic ddr3_i,
  output logic keep_o,
  output logic freq_o,
  output logic ddr3_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_o <= 1'b0;
      freq_o <= 1'b0;
      ddr3_o <= 1'b0;
    end else if (capture_i) begin
      keep_o <= keep_i;
      freq_o <= freq_i;
      ddr3_o <= ddr3_i;
    end
  end
endmodule

// File: rtl/dclk_relock_seq.sv
module dclk_relock_seq #(
  parameter int unsigned LOCK_CYCLES = 9000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic keep_i,
  input  logic freq_change_i,
  input  logic ddr3_i,
  input  logic ctrl_idle_i,
  input  logic sr_ack_i,
  input  logic clkgen_ack_i,
  output logic dll_rst_o,
  output logic sr_req_o,
  output logic clkgen_req_o,
  output logic zq_long_o,
  output logic busy_o,
  output logic done_o
);
  import relock_pkg::*;

  localparam int unsigned CW = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;

  relock_state_e state_q, state_d;
  logic keep_q, freq_q, ddr3_q;

  // Named internal events
  logic start_accept;
  logic lock_load;
  logic lock_expired;
  logic sr_exit_seen;
  logic in_clk_phase;

  assign start_accept = (state_q == ST_IDLE) && start_i;
  assign lock_load    = (state_q == ST_CLK_DROP) && !clkgen_ack_i;
  assign sr_exit_seen = (state_q == ST_SR_EXIT) && !sr_ack_i;
  assign in_clk_phase = (state_q == ST_CLK_REQ) || (state_q == ST_CLK_DROP)
                     || (state_q == ST_LOCK);

  relock_opt_reg u_opts (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (start_accept),
    .keep_i    (keep_i),
    .freq_i    (freq_change_i),
    .ddr3_i    (ddr3_i),
    .keep_o    (keep_q),
    .freq_o    (freq_q),
    .ddr3_o    (ddr3_q)
  );

  relock_wait_timer #(
    .CYCLES (LOCK_CYCLES),
    .CW     (CW)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (lock_load),
    .run_i  (state_q == ST_LOCK),
    .zero_o (lock_expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = keep_i ? ST_WAIT_IDLE
                                         : (freq_change_i ? ST_CLK_REQ : ST_FINISH);
      ST_WAIT_IDLE: if (ctrl_idle_i)   state_d = ST_SR_ENTER;
      ST_SR_ENTER:  if (sr_ack_i)      state_d = freq_q ? ST_CLK_REQ : ST_SR_EXIT;
      ST_CLK_REQ:   if (clkgen_ack_i)  state_d = ST_CLK_DROP;
      ST_CLK_DROP:  if (!clkgen_ack_i) state_d = ST_LOCK;
      ST_LOCK:      if (lock_expired)  state_d = keep_q ? ST_SR_EXIT : ST_FINISH;
      ST_SR_EXIT:   if (sr_exit_seen)  state_d = ST_FINISH;
      ST_FINISH:                       state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign dll_rst_o    = (state_q == ST_CLK_REQ) || (state_q == ST_CLK_DROP);
  assign clkgen_req_o = (state_q == ST_CLK_REQ);
  assign sr_req_o     = (state_q == ST_SR_ENTER) || (keep_q && in_clk_phase);
  assign done_o       = (state_q == ST_FINISH);
  assign zq_long_o    = (state_q == ST_FINISH) && keep_q && ddr3_q;
  assign busy_o       = (state_q != ST_IDLE);

  // R2: a clock request only exists while the DLL is held in reset
  assert_clkreq_in_dllrst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clkgen_req_o |-> dll_rst_o);

  // R3: DLL reset is released only after the acknowledge was seen low
  assert_dll_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dll_rst_o) |-> $past(!clkgen_ack_i));

  // R5: with self-refresh requested, DLL reset starts only after the acknowledge
  assert_sr_before_dll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dll_rst_o) && sr_req_o) |-> $past(sr_ack_i));

  // R6: completion of a preserving run follows a low self-refresh acknowledge
  assert_done_after_sr_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && keep_q) |-> $past(!sr_ack_i));

  // R9: the ZQ request only accompanies completion
  assert_zq_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zq_long_o |-> done_o);

  // R11: completion is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/dclk_relock_seq_bench.sv
module dclk_relock_seq_bench;
  localparam int LOCK = 9000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start_i, keep_i, freq_change_i, ddr3_i, ctrl_idle_i, sr_ack_i, clkgen_ack_i;
  logic dll_rst_o, sr_req_o, clkgen_req_o, zq_long_o, busy_o, done_o;

  dclk_relock_seq #(.LOCK_CYCLES(LOCK)) u_dclk_relock_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .keep_i(keep_i),
    .freq_change_i(freq_change_i), .ddr3_i(ddr3_i), .ctrl_idle_i(ctrl_idle_i),
    .sr_ack_i(sr_ack_i), .clkgen_ack_i(clkgen_ack_i), .dll_rst_o(dll_rst_o),
    .sr_req_o(sr_req_o), .clkgen_req_o(clkgen_req_o), .zq_long_o(zq_long_o),
    .busy_o(busy_o), .done_o(done_o));

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0;

  // model phases
  localparam int P_IDLE = 0, P_WIDLE = 1, P_SRIN = 2, P_CREQ = 3,
                 P_CDROP = 4, P_LOCK = 5, P_SROUT = 6, P_FIN = 7;
  int ph = P_IDLE, m_cnt = 0;
  bit m_keep, m_freq, m_ddr3;

  int sr_dly = 3, cg_dly = 4, sr_c = 0, cg_c = 0;
  bit saw_dll, saw_sr, saw_zq, prev_dll;
  longint dll_fall_cyc = 0, lock_len = 0;
  int done_cnt = 0;

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = P_IDLE; sr_ack_i = 1'b0; clkgen_ack_i = 1'b0; sr_c = 0; cg_c = 0; prev_dll = 1'b0;
    end else begin
      // compare against the model
      check("R11", "busy",    busy_o,       ph != P_IDLE);
      check("R3",  "dll_rst", dll_rst_o,    ph == P_CREQ || ph == P_CDROP);
      check("R2",  "clk_req", clkgen_req_o, ph == P_CREQ);
      check("R5",  "sr_req",  sr_req_o,
            ph == P_SRIN || (m_keep && (ph == P_CREQ || ph == P_CDROP || ph == P_LOCK)));
      check("R11", "done",    done_o,       ph == P_FIN);
      check("R9",  "zq_long", zq_long_o,    ph == P_FIN && m_keep && m_ddr3);
      // monitors
      if (dll_rst_o) saw_dll = 1'b1;
      if (prev_dll && !dll_rst_o) dll_fall_cyc = cyc;
      prev_dll = dll_rst_o;
      if (sr_req_o) saw_sr = 1'b1;
      if (zq_long_o) saw_zq = 1'b1;
      if (done_o) begin done_cnt++; lock_len = cyc - dll_fall_cyc; end
      // responders with fixed lag
      if (sr_req_o != sr_ack_i) begin
        sr_c++; if (sr_c >= sr_dly) begin sr_ack_i = sr_req_o; sr_c = 0; end
      end else sr_c = 0;
      if (clkgen_req_o != clkgen_ack_i) begin
        cg_c++; if (cg_c >= cg_dly) begin clkgen_ack_i = clkgen_req_o; cg_c = 0; end
      end else cg_c = 0;
      // model step, seeing the inputs of the coming edge
      case (ph)
        P_IDLE: if (start_i) begin
          m_keep = keep_i; m_freq = freq_change_i; m_ddr3 = ddr3_i;
          ph = keep_i ? P_WIDLE : (freq_change_i ? P_CREQ : P_FIN);
        end
        P_WIDLE: if (ctrl_idle_i) ph = P_SRIN;
        P_SRIN:  if (sr_ack_i) ph = m_freq ? P_CREQ : P_SROUT;
        P_CREQ:  if (clkgen_ack_i) ph = P_CDROP;
        P_CDROP: if (!clkgen_ack_i) begin ph = P_LOCK; m_cnt = LOCK; end
        P_LOCK:  begin m_cnt--; if (m_cnt == 0) ph = m_keep ? P_SROUT : P_FIN; end
        P_SROUT: if (!sr_ack_i) ph = P_FIN;
        default: ph = P_IDLE;
      endcase
    end
  end

  task automatic run(bit k, bit f, bit d, int idle_delay, int poke);
    int base;
    saw_dll = 0; saw_sr = 0; saw_zq = 0;
    base = done_cnt;
    @(posedge clk); #1;
    keep_i = k; freq_change_i = f; ddr3_i = d; ctrl_idle_i = (idle_delay == 0); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    for (int i = 0; i < 30000; i++) begin
      @(posedge clk); #1;
      if (i == idle_delay) ctrl_idle_i = 1'b1;
      if (i == poke) begin start_i = 1'b1; keep_i = 1'b1; freq_change_i = 1'b0; end
      else if (i == poke + 1) start_i = 1'b0;
      if (done_cnt > base) break;
    end
    check("R11", "run completed", done_cnt - base, 1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 0; keep_i = 0; freq_change_i = 0; ddr3_i = 0;
    ctrl_idle_i = 0; sr_ack_i = 0; clkgen_ack_i = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "outputs in reset",
          {dll_rst_o, sr_req_o, clkgen_req_o, zq_long_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "outputs after reset",
          {dll_rst_o, sr_req_o, clkgen_req_o, zq_long_o, busy_o, done_o}, 0);

    // cold path with a frequency change
    run(1'b0, 1'b1, 1'b1, 0, -5);
    check("R3", "dll reset raised", saw_dll, 1);
    check("R4", "settle length cold", int'(lock_len), LOCK);
    check("R8", "no self-refresh cold", saw_sr, 0);
    check("R9", "no zq cold", saw_zq, 0);

    // preserving path, DDR3, controller busy for a while
    run(1'b1, 1'b1, 1'b1, 7, -5);
    check("R5", "self-refresh used", saw_sr, 1);
    check("R9", "zq on ddr3 exit", saw_zq, 1);
    check("R6", "sr exit after settle", int'(lock_len > LOCK), 1);

    // preserving path, no frequency change, not DDR3
    run(1'b1, 1'b0, 1'b0, 3, -5);
    check("R7", "no dll reset", saw_dll, 0);
    check("R5", "self-refresh used", saw_sr, 1);
    check("R9", "no zq without ddr3", saw_zq, 0);

    // cold path, no frequency change
    run(1'b0, 1'b0, 1'b1, 0, -5);
    check("R7", "no dll reset", saw_dll, 0);
    check("R8", "no self-refresh", saw_sr, 0);

    // second start during the settle wait is ignored
    run(1'b0, 1'b1, 1'b0, 0, 40);
    check("R10", "restart ignored, no self-refresh", saw_sr, 0);
    check("R10", "settle length unchanged", int'(lock_len), LOCK);
    @(posedge clk); #1;
    check("R11", "done low after pulse", done_o, 0);
    check("R11", "idle after done", busy_o, 0);
    repeat (5) @(posedge clk);
    #1;
    check("R10", "no second run", done_cnt, 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule